// File: doc/BRIEF.md
# Vertical Scan Start Wait Timer

This block sets the moment the vertical scan begins. It counts line periods from a chosen edge of the incoming vertical sync pulse. When the count is complete it raises a start pulse that lasts one line period. The ramp generator downstream uses that pulse to begin a field. Line periods arrive as single-cycle `line_tick` strobes in the block's clock domain.

Two controls select the edge that counting starts from and whether the programmed wait is used:

- **Multi-sync mode** counts the programmed wait from the rising edge of vertical sync.
- **TV mode with the select bit set** counts the programmed wait from the falling edge.
- **TV mode with the select bit clear** ignores the programmed wait. It always starts the scan a fixed number of lines after the rising edge.

The programmed wait has a floor. A setting below the floor produces the floor delay.

The mode and the wait setting are sampled only at the reference edge. Each field therefore runs with the values that were present when it began. A fresh reference edge during a running wait restarts the count, and the start that was pending is dropped.

Top module: `vscan_wait_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `scan_start` is 0 and no wait is running.
- R2: With `mode_msync`=1 and `wait_set`>=8, `scan_start` first reads 1 after the `wait_set`-th `line_tick` that follows the rising edge of `vsync_in`.
- R3: In the counting modes a `wait_set` value below 8 (0..7) gives the same start position as a value of 8.
- R4: With `mode_msync`=0 and `vsr_sel`=1, the wait is counted from the falling edge of `vsync_in`. The rising edge does not start a count.
- R5: With `mode_msync`=0 and `vsr_sel`=0, the start comes 8 line ticks after the rising edge of `vsync_in`, whatever the value of `wait_set`.
- R6: `scan_start` rises at the clock edge that takes the final counted tick. It stays high until the next `line_tick`, so it is high for exactly one line period.
- R7: A new reference edge during a running wait reloads the count. The earlier pending start never appears, and the start follows the full delay counted from the new edge.
- R8: A change to `wait_set` after the reference edge does not alter the running field's delay, and the count holds steady between ticks.
- R9: A `line_tick` in the same cycle as the reference edge is not counted. An edge of `vsync_in` that is not the reference edge for the current mode leaves a running count untouched.
- R10: Line ticks with no wait running never produce a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle strobe per line period |
| vsync_in | input | 1 | Incoming vertical sync level (active high) |
| wait_set | input | WAIT_W | Programmed wait in line periods |
| mode_msync | input | 1 | 1 = multi-sync mode, 0 = TV mode |
| vsr_sel | input | 1 | TV-mode reference select: 1 = falling edge with programmed wait, 0 = fixed start |
| scan_start | output | 1 | Start-of-vertical-scan pulse, one line period wide |

## Verification
The bench builds the block with its default parameters: a 6-bit wait, a floor of 8, a fixed start of 8 and no input synchronizer stages. With a 6-bit wait the whole setting range is reachable, from 0 through the floor up to the 63-line maximum. With no synchronizer stages, each sync edge loads the counter at the very next clock edge. Tick-exact positions can therefore be predicted for the restart, coincident-tick and non-reference-edge cases. The fixed start equals the floor, so the fixed mode is told apart from the clamp by using large settings such as 40.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

   typedef enum logic {
      REF_LEAD  = 1'b0,
      REF_TRAIL = 1'b1
   } ref_kind_t;

   typedef struct packed {
      ref_kind_t edge_kind;
      logic      use_fixed;
   } field_plan_t;

   function automatic field_plan_t plan_for(input logic msync, input logic vsr);
      field_plan_t p;
      if (msync) begin
         p.edge_kind = REF_LEAD;
         p.use_fixed = 1'b0;
      end else if (vsr) begin
         p.edge_kind = REF_TRAIL;
         p.use_fixed = 1'b0;
      end else begin
         p.edge_kind = REF_LEAD;
         p.use_fixed = 1'b1;
      end
      return p;
   endfunction

endpackage

// File: rtl/vsw_edge_pick.sv
module vsw_edge_pick
   import vsw_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync_in,
   input  logic msync,
   input  logic vsr,
   output logic ref_evt,
   output logic fixed_sel
);

   logic        vs_now;
   logic        vs_prev;
   logic        lead;
   logic        trail;
   field_plan_t plan;

   if (SYNC_STAGES < 0) begin : g_bad_stages
      $error("vsw_edge_pick: SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign vs_now = vsync_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain[0] <= vsync_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               chain[i] <= chain[i-1];
            end
         end
      end
      assign vs_now = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_prev <= 1'b0;
      end else begin
         vs_prev <= vs_now;
      end
   end

   assign lead  = vs_now & ~vs_prev;
   assign trail = ~vs_now & vs_prev;

   always_comb begin
      plan      = plan_for(msync, vsr);
      fixed_sel = plan.use_fixed;
      ref_evt   = (plan.edge_kind == REF_TRAIL) ? trail : lead;
   end

endmodule

// File: rtl/vsw_delay_sel.sv
module vsw_delay_sel #(
   parameter int WAIT_W     = 6,
   parameter int MIN_WAIT   = 8,
   parameter int FIXED_WAIT = 8
) (
   input  logic [WAIT_W-1:0] wait_set,
   input  logic              fixed_sel,
   output logic [WAIT_W-1:0] load_val
);

   localparam logic [WAIT_W-1:0] FLOOR_V = WAIT_W'(MIN_WAIT);
   localparam logic [WAIT_W-1:0] FIXED_V = WAIT_W'(FIXED_WAIT);

   if (FIXED_WAIT < 1 || FIXED_WAIT >= (1 << WAIT_W)) begin : g_bad_fixed
      $error("vsw_delay_sel: FIXED_WAIT out of range for WAIT_W");
   end

   always_comb begin
      if (fixed_sel) begin
         load_val = FIXED_V;
      end else if (wait_set < FLOOR_V) begin
         load_val = FLOOR_V;
      end else begin
         load_val = wait_set;
      end
   end

endmodule

// File: rtl/vsw_line_count.sv
module vsw_line_count #(
   parameter int CNT_W    = 6,
   parameter int MIN_LOAD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             line_tick,
   output logic             start_pulse
);

   localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);
   localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(MIN_LOAD);

   logic [CNT_W-1:0] cnt;
   logic             busy;
   logic             last_line;

   assign last_line = busy && !load && (cnt == ONE_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (load) begin
         cnt  <= load_val;
         busy <= 1'b1;
      end else if (busy && line_tick) begin
         cnt <= cnt - ONE_V;
         if (cnt == ONE_V) begin
            busy <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
      end else if (line_tick) begin
         start_pulse <= last_line;
      end
   end

   // R6
   start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse && !line_tick |=> start_pulse);

   // R6
   start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse && line_tick |=> !start_pulse);

   // R7
   reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy && (cnt == $past(load_val)));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && line_tick && !load |=> cnt == ($past(cnt) - ONE_V));

   // R8
   hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !line_tick && !load |=> busy && $stable(cnt));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !$rose(start_pulse));

   // R3
   floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> load_val >= FLOOR_V);

endmodule

// File: rtl/vscan_wait_timer.sv
module vscan_wait_timer #(
   parameter int WAIT_W      = 6,
   parameter int MIN_WAIT    = 8,
   parameter int FIXED_WAIT  = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              vsync_in,
   input  logic [WAIT_W-1:0] wait_set,
   input  logic              mode_msync,
   input  logic              vsr_sel,
   output logic              scan_start
);

   localparam int CNT_W = WAIT_W;
   localparam int FLOOR = (MIN_WAIT < FIXED_WAIT) ? MIN_WAIT : FIXED_WAIT;

   if (WAIT_W < 2) begin : g_bad_width
      $error("vscan_wait_timer: WAIT_W must be at least 2");
   end
   if (MIN_WAIT < 1 || MIN_WAIT >= (1 << WAIT_W)) begin : g_bad_min
      $error("vscan_wait_timer: MIN_WAIT out of range for WAIT_W");
   end

   logic              ref_evt;
   logic              fixed_sel;
   logic [CNT_W-1:0]  load_val;

   vsw_edge_pick #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .vsync_in  (vsync_in),
      .msync     (mode_msync),
      .vsr       (vsr_sel),
      .ref_evt   (ref_evt),
      .fixed_sel (fixed_sel)
   );

   vsw_delay_sel #(
      .WAIT_W     (WAIT_W),
      .MIN_WAIT   (MIN_WAIT),
      .FIXED_WAIT (FIXED_WAIT)
   ) u_delay (
      .wait_set  (wait_set),
      .fixed_sel (fixed_sel),
      .load_val  (load_val)
   );

   vsw_line_count #(
      .CNT_W    (CNT_W),
      .MIN_LOAD (FLOOR)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (ref_evt),
      .load_val    (load_val),
      .line_tick   (line_tick),
      .start_pulse (scan_start)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !scan_start);

endmodule

// File: tb/vscan_wait_timer_bench.sv
module vscan_wait_timer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_tick = 1'b0;
   logic       vsync_in = 1'b0;
   logic [5:0] wait_set = '0;
   logic       mode_msync = 1'b1;
   logic       vsr_sel = 1'b0;
   logic       scan_start;

   int  tests = 0;
   int  fails = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   vscan_wait_timer u_vscan_wait_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_tick  (line_tick),
      .vsync_in   (vsync_in),
      .wait_set   (wait_set),
      .mode_msync (mode_msync),
      .vsr_sel    (vsr_sel),
      .scan_start (scan_start)
   );

   typedef struct packed {
      logic       ms;
      logic       vs;
      logic [5:0] w;
      logic [7:0] exp;
   } vec_t;

   // expected = line index (counted from the rising edge) of the first high sample;
   // falling-edge fields add 3 because the sync falls after line 3
   localparam vec_t VEC [11] = '{
      '{1'b1, 1'b0, 6'd20, 8'd20},
      '{1'b1, 1'b1, 6'd9,  8'd9 },
      '{1'b1, 1'b0, 6'd63, 8'd63},
      '{1'b1, 1'b0, 6'd8,  8'd8 },
      '{1'b1, 1'b0, 6'd5,  8'd8 },
      '{1'b1, 1'b0, 6'd0,  8'd8 },
      '{1'b0, 1'b0, 6'd40, 8'd8 },
      '{1'b0, 1'b0, 6'd3,  8'd8 },
      '{1'b0, 1'b1, 6'd12, 8'd15},
      '{1'b0, 1'b1, 6'd2,  8'd11},
      '{1'b0, 1'b1, 6'd63, 8'd66}
   };

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic run_line(input int k, input int fall_k, input int rise_k,
                           input int chg_k, input logic [5:0] chg_w, output bit hi);
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      if (k == fall_k) vsync_in = 1'b0;
      if (k == rise_k) vsync_in = 1'b1;
      if (k == chg_k)  wait_set = chg_w;
      @(negedge clk);
      @(negedge clk);
      hi = scan_start;
   endtask

   task automatic run_field(input logic ms, input logic vs, input logic [5:0] w,
                            input int exp_k, input int restart_k, input int chg_k,
                            input logic [5:0] chg_w, input string tag);
      int first_hi = 0;
      int hi_cnt = 0;
      bit hi;
      mode_msync = ms;
      vsr_sel    = vs;
      wait_set   = w;
      @(negedge clk);
      vsync_in = 1'b1;
      @(negedge clk);
      for (int k = 1; k <= 75; k++) begin
         run_line(k, (k == 3 || (restart_k > 0 && k == restart_k + 3)) ? k : -1,
                  restart_k, chg_k, chg_w, hi);
         if (hi) begin
            hi_cnt++;
            if (first_hi == 0) first_hi = k;
         end
      end
      vsync_in = 1'b0;
      @(negedge clk);
      check(first_hi == exp_k, tag, first_hi, exp_k);
      check(hi_cnt == 1, "R6", hi_cnt, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      bit hi;
      int cnt;
      int first_hi;
      string tag;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(scan_start == 1'b0, "R1", int'(scan_start), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(scan_start == 1'b0, "R1", int'(scan_start), 0);

      // R10: ticks with no wait running
      cnt = 0;
      for (int k = 1; k <= 12; k++) begin
         run_line(k, -1, -1, -1, 6'd0, hi);
         if (hi) cnt++;
      end
      check(cnt == 0, "R10", cnt, 0);

      for (int i = 0; i < 11; i++) begin
         if (VEC[i].ms) tag = (VEC[i].w < 6'd8) ? "R3" : "R2";
         else           tag = VEC[i].vs ? "R4" : "R5";
         run_field(VEC[i].ms, VEC[i].vs, VEC[i].w, int'(VEC[i].exp), 0, -1, 6'd0, tag);
      end

      // R7: restart at line 10 drops the start due at 20
      run_field(1'b1, 1'b0, 6'd20, 30, 10, -1, 6'd0, "R7");

      // R8: setting raised to 40 mid-field, field still uses 20
      run_field(1'b1, 1'b0, 6'd20, 20, 0, 5, 6'd40, "R8");
      // R8: next field picks up the new setting
      run_field(1'b1, 1'b0, 6'd40, 40, 0, -1, 6'd0, "R8");

      // R9: tick in the same cycle as the reference edge is not counted
      mode_msync = 1'b1;
      vsr_sel    = 1'b0;
      wait_set   = 6'd10;
      @(negedge clk);
      vsync_in  = 1'b1;
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      @(negedge clk);
      first_hi = 0;
      for (int k = 1; k <= 20; k++) begin
         run_line(k, (k == 3) ? k : -1, -1, -1, 6'd0, hi);
         if (hi && first_hi == 0) first_hi = k;
      end
      check(first_hi == 10, "R9", first_hi, 10);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule